// File: doc/BRIEF.md
# Comparator Deglitch Filter with PWM Shutdown

This block takes the digital output of an analog comparator and filters out short glitches. The comparator bit is first brought into the reference clock domain. A rising edge then starts a delay counter. The counter is programmed through a small control register. If the comparator is still high when the count completes, the block raises a shutdown event. That event either stops the PWM timer outright or parks the high-side PWM outputs for the rest of the current PWM period.

Software programs a single 8-bit control byte. The byte enables the comparator path, enables the filter (active low), picks the shutdown mode, sets the delay and chooses what drives wakeup input 6. The PWM timer supplies an end-of-period pulse. In return it receives a one-clock disable pulse or a rest level. The external pin for wakeup input 6 passes through a selector. When selected, the shutdown event replaces that pin.

Top module: `cmp_glitch_shutdown`

## Requirements
- R1: The control register resets to 0x00, is loaded from `cfg_wdata` on a clock edge where `cfg_wr` is high, and is always visible on `cfg_rdata`.
- R2: With control bit 7 (comparator enable) at 0, `shut_evt`, `tmr_kill` and `hs_rest` stay low whatever `cmp_raw` does.
- R3: With control bit 5 at 1 (filter off; active-low enable), `shut_evt`, `tmr_kill` and `hs_rest` stay low.
- R4: With bit 7 = 1 and bit 5 = 0, let edge 1 be the first rising clock edge that samples `cmp_raw` high. With the delay field D in bits 3..0, `shut_evt` is high after edge D+3, provided `cmp_raw` is sampled high on edges 1 through D+1. D = 0 therefore fires one clock after the synchronized rising edge.
- R5: If `cmp_raw` is sampled high on fewer than D+1 consecutive edges, `shut_evt` never rises for that pulse.
- R6: Once fired, `shut_evt` falls after edge k+2, where edge k is the first edge that samples `cmp_raw` low.
- R7: With bit 4 = 0 (disable mode), `tmr_kill` is high for exactly one clock: the first clock in which `shut_evt` is high. `hs_rest` stays low in this mode.
- R8: With bit 4 = 1 (period-blank mode), `hs_rest` equals `shut_evt`. A `pwm_cycle_end` pulse sampled while `shut_evt` is high drops both after that edge, even if the comparator is still high. No new event occurs until the comparator goes low and rises again.
- R9: With bit 4 = 1, `tmr_kill` is never asserted.
- R10: `wake6_src` follows `shut_evt` when bit 6 is 1 and `ext_wake6` when bit 6 is 0, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| pwm_cycle_end | input | 1 | One-clock pulse at the end of each PWM period |
| ext_wake6 | input | 1 | External pin for wakeup input 6 |
| shut_evt | output | 1 | Qualified shutdown event level |
| tmr_kill | output | 1 | One-clock pulse that disables the timer and clears its enable and counter |
| hs_rest | output | 1 | Forces the high-side PWM outputs to their rest state |
| wake6_src | output | 1 | Selected source for wakeup input 6 |

## Verification
The input path has fixed latencies, and the bench counts from the first clock edge that samples `cmp_raw` high. The event appears after edge D+3: two synchronizer stages, one edge-detect register, then D counts. It clears after edge k+2 from the first low sample. Register writes show on readback one edge after the strobe. The wakeup selector has no delay, and release in period-blank mode takes effect on the edge that samples `pwm_cycle_end`. The bench drives inputs on falling edges and samples on the next falling edge. It records the index of the first edge with the event high, the number of clocks it stays high, and the number of kill and rest clocks. It compares these with per-vector expected values worked out from the formulas above.

// File: rtl/cds_pkg.sv
package cds_pkg;

  localparam int CDS_DLY_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FIRED = 2'd2,
    ST_SPENT = 2'd3
  } cds_state_e;

  typedef struct packed {
    logic                 cmp_en;
    logic                 wake_sel;
    logic                 filt_off;
    logic                 cycle_mode;
    logic [CDS_DLY_W-1:0] delay;
  } cds_ctl_t;

  // True when the running count has reached the programmed delay
  function automatic logic count_done(input logic [CDS_DLY_W-1:0] cnt,
                                      input logic [CDS_DLY_W-1:0] lim);
    return cnt == lim;
  endfunction

  // Clock edges from first high sample of the raw input to the event
  function automatic int fire_latency(input int dly, input int sync_stages);
    return dly + sync_stages + 1;
  endfunction

endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cds_qualifier.sv
module cds_qualifier
  import cds_pkg::*;
#(
  parameter int DLY_W = CDS_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_q,
  input  logic             filt_off,
  input  logic             cycle_mode,
  input  logic [DLY_W-1:0] delay,
  input  logic             pwm_cycle_end,
  output logic             shut,
  output logic             kill,
  output logic             spent
);
  cds_state_e       state, state_nx;
  logic [DLY_W-1:0] cnt, cnt_nx;
  logic             cmp_d, cmp_rise, shut_d;

  assign cmp_rise = cmp_q & ~cmp_d;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (filt_off) begin
      state_nx = ST_IDLE;
      cnt_nx   = '0;
    end else begin
      unique case (state)
        ST_IDLE:
          if (cmp_rise) begin
            if (count_done('0, delay)) state_nx = ST_FIRED;
            else begin
              state_nx = ST_COUNT;
              cnt_nx   = DLY_W'(1);
            end
          end
        ST_COUNT:
          if (!cmp_q)                        state_nx = ST_IDLE;
          else if (count_done(cnt, delay))   state_nx = ST_FIRED;
          else                               cnt_nx   = cnt + DLY_W'(1);
        ST_FIRED:
          if (!cmp_q)                          state_nx = ST_IDLE;
          else if (cycle_mode && pwm_cycle_end) state_nx = ST_SPENT;
        ST_SPENT:
          if (!cmp_q) state_nx = ST_IDLE;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cmp_d  <= 1'b0;
      shut_d <= 1'b0;
    end else begin
      state  <= state_nx;
      cnt    <= cnt_nx;
      cmp_d  <= cmp_q;
      shut_d <= shut;
    end
  end

  assign shut  = (state == ST_FIRED);
  assign spent = (state == ST_SPENT);
  assign kill  = shut & ~shut_d & ~cycle_mode & ~filt_off;

  // R3: filter disabled means no event on the following cycle
  p_filter_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    filt_off |=> !shut);
  // R2 / R6: a low qualified comparator clears the event by the next cycle
  p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_q |=> !shut);
  // R4: an event only starts while the comparator was high
  p_fire_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut) |-> $past(cmp_q));
  // R7: disable pulse is a single clock
  p_kill_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !kill);
  // R8: end of PWM period releases a blank-mode event
  p_release_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && cycle_mode && pwm_cycle_end && !filt_off) |=> !shut);
  // R8: no refire while waiting for a fresh rising edge
  p_no_refire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spent |=> !shut);
endmodule

// File: rtl/cmp_glitch_shutdown.sv
module cmp_glitch_shutdown
  import cds_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTL_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             cfg_wr,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic [CTL_W-1:0] cfg_rdata,
  input  logic             pwm_cycle_end,
  input  logic             ext_wake6,
  output logic             shut_evt,
  output logic             tmr_kill,
  output logic             hs_rest,
  output logic             wake6_src
);
  localparam int DLY_W = CDS_DLY_W;

  cds_ctl_t ctl;
  logic     cmp_sync, cmp_q, spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (cfg_wr) ctl <= cds_ctl_t'(cfg_wdata);
  end

  assign cfg_rdata = CTL_W'(ctl);

  cds_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmp_raw),
    .dout  (cmp_sync)
  );

  assign cmp_q = cmp_sync & ctl.cmp_en;

  cds_qualifier #(.DLY_W(DLY_W)) u_qual (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_q         (cmp_q),
    .filt_off      (ctl.filt_off),
    .cycle_mode    (ctl.cycle_mode),
    .delay         (ctl.delay),
    .pwm_cycle_end (pwm_cycle_end),
    .shut          (shut_evt),
    .kill          (tmr_kill),
    .spent         (spent)
  );

  assign hs_rest   = shut_evt & ctl.cycle_mode;
  assign wake6_src = ctl.wake_sel ? shut_evt : ext_wake6;

  // R1: a write shows on readback one edge later
  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));
  // R9: blank mode never pulses the timer disable
  p_no_kill_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cycle_mode && $past(ctl.cycle_mode)) |-> !tmr_kill);
  // R2: comparator path off keeps the event low one cycle later
  p_cmp_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cmp_en && $past(!ctl.cmp_en)) |-> !shut_evt);
endmodule

// File: tb/cmp_glitch_shutdown_test.sv
module cmp_glitch_shutdown_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       pwm_cycle_end = 1'b0;
  logic       ext_wake6 = 1'b0;
  logic       shut_evt, tmr_kill, hs_rest, wake6_src;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cmp_glitch_shutdown uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pwm_cycle_end(pwm_cycle_end), .ext_wake6(ext_wake6),
    .shut_evt(shut_evt), .tmr_kill(tmr_kill), .hs_rest(hs_rest),
    .wake6_src(wake6_src)
  );

  // ctl, high edges, first event edge (0 = none), event clocks, kill clocks, rest clocks
  typedef struct packed {
    logic [7:0] ctl; int len; int first; int high; int kills; int rests;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h80,  1,  3, 1, 1, 0},   // R4 D=0
    '{8'h83,  3,  0, 0, 0, 0},   // R5 too short
    '{8'h83,  6,  6, 3, 1, 0},   // R4 R6 R7
    '{8'h8F, 15,  0, 0, 0, 0},   // R5 one edge short
    '{8'h8F, 20, 18, 5, 1, 0},   // R4 D=15
    '{8'h05, 10,  0, 0, 0, 0},   // R2 comparator off
    '{8'hA2, 10,  0, 0, 0, 0},   // R3 filter off
    '{8'h92,  8,  5, 6, 0, 6}    // R8 R9 blank mode
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4ms;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first, high, kills, rests;
    idle(3);
    // reset state R1
    check("R1 reset rdata", cfg_rdata, 8'h00);
    check("R1 reset shut", shut_evt, 0);
    check("R7 reset kill", tmr_kill, 0);
    check("R8 reset rest", hs_rest, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    write_ctl(8'h5A);
    check("R1 readback", cfg_rdata, 8'h5A);

    for (int v = 0; v < NV; v++) begin
      write_ctl(VECS[v].ctl);
      idle(4);
      first = 0; high = 0; kills = 0; rests = 0;
      cmp_raw = 1'b1;
      for (int e = 1; e <= VECS[v].len + 6; e++) begin
        @(posedge clk);
        @(negedge clk);
        if (e == VECS[v].len) cmp_raw = 1'b0;
        if (shut_evt) begin
          if (first == 0) first = e;
          high++;
        end
        if (tmr_kill) kills++;
        if (hs_rest)  rests++;
      end
      check($sformatf("R4 R5 first edge vec%0d", v), first, VECS[v].first);
      check($sformatf("R6 event length vec%0d", v), high, VECS[v].high);
      check($sformatf("R7 R9 kill clocks vec%0d", v), kills, VECS[v].kills);
      check($sformatf("R8 rest clocks vec%0d", v), rests, VECS[v].rests);
    end

    // R10 wakeup source selection
    write_ctl(8'hC0);
    idle(3);
    ext_wake6 = 1'b0;
    cmp_raw = 1'b1;
    idle(4);
    check("R10 wake follows event", wake6_src, 1);
    write_ctl(8'h80);
    check("R10 event still high", shut_evt, 1);
    check("R10 wake follows pin low", wake6_src, 0);
    ext_wake6 = 1'b1;
    #1;
    check("R10 wake follows pin high", wake6_src, 1);
    cmp_raw = 1'b0;
    ext_wake6 = 1'b0;
    idle(5);

    // R8 release at end of PWM period and no refire
    write_ctl(8'h91);
    idle(3);
    cmp_raw = 1'b1;
    idle(4);
    check("R8 blank fired", shut_evt, 1);
    check("R8 rest high", hs_rest, 1);
    pwm_cycle_end = 1'b1;
    @(negedge clk);
    pwm_cycle_end = 1'b0;
    check("R8 released shut", shut_evt, 0);
    check("R8 released rest", hs_rest, 0);
    high = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (shut_evt) high++;
    end
    check("R8 no refire while high", high, 0);
    cmp_raw = 1'b0;
    idle(5);
    cmp_raw = 1'b1;
    idle(4);
    check("R8 refire after fresh edge", shut_evt, 1);
    cmp_raw = 1'b0;
    idle(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule